// File: doc/BRIEF.md
# Trigger-Synchronized Timer Pair

Two identical 16-bit up-counters share one clock. Each has a clock divider, a reload limit, a run bit, a counter-reset strobe, a sticky trigger flag, a selectable trigger output, a trigger-source selector and a slave-mode selector. The trigger output of timer A feeds the peer-trigger input of timer B, and the reverse. Both timers can also watch a shared external line for rising edges. One register-write port, with a timer-select bit, configures both timers.

In trigger mode a selected trigger event sets the run bit in hardware. Software clears it again. When the sync-delay bit of a master timer is set, the master holds back its own count start and flag by one cycle. A single external edge then starts the master and its slave on the same clock, with the same counter values from then on. Writing a counter directly loads an offset between the two timers.

Register map per timer (`wrAddr`): 0 control (bit0 run, bit1 sync delay); 1 mode (bits 2:0 trigger-output select, bits 6:4 trigger source, bits 10:8 slave mode); 2 divider; 3 reload limit; 4 counter load; 5 event (bit0 = counter reset); 6 status (write bit0 = 0 to clear the flag).

Top module: `trig_timer_pair`

## Requirements
- R1: While reset is asserted and after it is released, both counters read 0, and both flags, run bits and trigger outputs are 0. After reset the divider is 0, the reload limit is 16'hFFFF and all mode fields are 0.
- R2: While a timer runs with divider value P, its counter advances once every P+1 clocks. The divider restarts when counting starts, so the first increment shows P+1 clocks after the run bit rises.
- R3: A counter at the reload limit wraps to 0 on its next increment. With trigger-output select 3'b010, the trigger output is high for exactly that one cycle, when the counter equals the limit and an increment is due.
- R4: With trigger-output select 3'b001, the trigger output equals the timer's run bit.
- R5: With slave mode 3'b110, a trigger event sets the run bit on the next clock. The counter resumes from whatever value it holds.
- R6: Trigger source 3'b001 takes the peer's trigger output, and 3'b100 takes a rising edge on the external input. Any other source produces no trigger. With slave mode other than 3'b110, a trigger sets neither the run bit nor the flag.
- R7: Each trigger event sets the flag, which stays set until a status write with bit0 = 0 clears it. A trigger in the same cycle as that clear leaves the flag set.
- R8: An event write with bit0 = 1 clears the counter and the divider. A counter-load write places the written value in the counter.
- R9: With the sync-delay bit set, the timer's counting and its flag take effect one cycle after its trigger, while its enable-mode trigger output rises at once. A slave triggered from that output starts counting, and flags, on the same cycle as the master.
- R10: A control write with bit0 = 0 clears the run bit and freezes the counter. A trigger in the same cycle keeps the run bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both timers |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Target timer: 0 = A, 1 = B |
| wrAddr | input | 3 | Register address |
| wrData | input | 16 | Write data |
| extIn | input | 1 | External trigger line, sampled for rising edges |
| cntA | output | 16 | Timer A counter |
| cntB | output | 16 | Timer B counter |
| trgoA | output | 1 | Timer A trigger output |
| trgoB | output | 1 | Timer B trigger output |
| flagA | output | 1 | Timer A trigger flag |
| flagB | output | 1 | Timer B trigger flag |
| runA | output | 1 | Timer A run bit |
| runB | output | 1 | Timer B run bit |

## Verification
A hardware trigger and a software write to the same bit can land in the same cycle: a trigger sets the flag while a status write clears it, or a trigger sets the run bit while a control write clears it. The bench drives an external rising edge on the same clock as each of these writes. Directly after that edge it expects the flag, or the run bit, to read 1. A separate write made without a trigger must then clear the bit, which shows that the write path works.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int TMR_W = 16;

  // register addresses
  localparam logic [2:0] ADR_CTRL = 3'd0;
  localparam logic [2:0] ADR_MODE = 3'd1;
  localparam logic [2:0] ADR_PSC  = 3'd2;
  localparam logic [2:0] ADR_ARR  = 3'd3;
  localparam logic [2:0] ADR_CNT  = 3'd4;
  localparam logic [2:0] ADR_EVT  = 3'd5;
  localparam logic [2:0] ADR_STAT = 3'd6;

  // trigger-output selections
  localparam logic [2:0] MM_RESET  = 3'b000;
  localparam logic [2:0] MM_ENABLE = 3'b001;
  localparam logic [2:0] MM_UPDATE = 3'b010;

  // trigger sources
  localparam logic [2:0] TS_PEER = 3'b001;
  localparam logic [2:0] TS_EXT  = 3'b100;

  // slave modes
  localparam logic [2:0] SM_TRIGGER = 3'b110;

  // strobes from the control half to the datapath half
  typedef struct packed {
    logic run;       // counting enabled this cycle
    logic pscClear;  // restart divider
    logic cntClear;  // counter to zero
    logic cntLoad;   // counter takes write data
  } dpCtl_t;
endpackage

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int W = TMR_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  dpCtl_t       ctl,
  input  logic [W-1:0] pscVal,
  input  logic [W-1:0] arrVal,
  input  logic [W-1:0] loadVal,
  output logic [W-1:0] cnt,
  output logic         uev
);
  logic [W-1:0] pscCnt;
  logic         tick;

  assign tick = ctl.run && (pscCnt == pscVal);
  assign uev  = tick && (cnt == arrVal);

  // divider: held at zero while stopped, so a start waits a full period
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pscCnt <= '0;
    end else if (ctl.pscClear || !ctl.run) begin
      pscCnt <= '0;
    end else if (tick) begin
      pscCnt <= '0;
    end else begin
      pscCnt <= pscCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (ctl.cntClear) begin
      cnt <= '0;
    end else if (ctl.cntLoad) begin
      cnt <= loadVal;
    end else if (tick) begin
      cnt <= uev ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int W = TMR_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic [2:0]   wrAddr,
  input  logic [W-1:0] wrData,
  input  logic         peerTrig,
  input  logic         extIn,
  input  logic         uev,
  output dpCtl_t       ctl,
  output logic [W-1:0] pscVal,
  output logic [W-1:0] arrVal,
  output logic [2:0]   masterSel,
  output logic         trgo,
  output logic         flag,
  output logic         cen
);
  logic [2:0] trigSrc, slaveMode;
  logic       syncDelay, cenDly, trigDly, extPrev;
  logic       ctrlWr, modeWr, pscWr, arrWr, cntWr, statWr, ugPulse;
  logic       srcHit, trigEvt, flagSet;

  assign ctrlWr  = wrEn && (wrAddr == ADR_CTRL);
  assign modeWr  = wrEn && (wrAddr == ADR_MODE);
  assign pscWr   = wrEn && (wrAddr == ADR_PSC);
  assign arrWr   = wrEn && (wrAddr == ADR_ARR);
  assign cntWr   = wrEn && (wrAddr == ADR_CNT);
  assign statWr  = wrEn && (wrAddr == ADR_STAT);
  assign ugPulse = wrEn && (wrAddr == ADR_EVT) && wrData[0];

  always_comb begin
    unique case (trigSrc)
      TS_PEER: srcHit = peerTrig;
      TS_EXT:  srcHit = extIn && !extPrev;
      default: srcHit = 1'b0;
    endcase
  end

  assign trigEvt = (slaveMode == SM_TRIGGER) && srcHit;
  assign flagSet = syncDelay ? trigDly : trigEvt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pscVal    <= '0;
      arrVal    <= '1;
      masterSel <= MM_RESET;
      trigSrc   <= '0;
      slaveMode <= '0;
      syncDelay <= 1'b0;
      cen       <= 1'b0;
      cenDly    <= 1'b0;
      trigDly   <= 1'b0;
      extPrev   <= 1'b0;
      flag      <= 1'b0;
    end else begin
      extPrev <= extIn;
      trigDly <= trigEvt;
      cenDly  <= cen;
      if (pscWr) pscVal <= wrData;
      if (arrWr) arrVal <= wrData;
      if (modeWr) begin
        masterSel <= wrData[2:0];
        trigSrc   <= wrData[6:4];
        slaveMode <= wrData[10:8];
      end
      if (ctrlWr) syncDelay <= wrData[1];
      // hardware set outranks a software write in the same cycle
      if (trigEvt)     cen <= 1'b1;
      else if (ctrlWr) cen <= wrData[0];
      if (flagSet)                  flag <= 1'b1;
      else if (statWr && !wrData[0]) flag <= 1'b0;
    end
  end

  always_comb begin
    unique case (masterSel)
      MM_RESET:  trgo = ugPulse;
      MM_ENABLE: trgo = cen;
      MM_UPDATE: trgo = uev;
      default:   trgo = 1'b0;
    endcase
  end

  always_comb begin
    ctl.run      = syncDelay ? (cen && cenDly) : cen;
    ctl.pscClear = ugPulse;
    ctl.cntClear = ugPulse;
    ctl.cntLoad  = cntWr;
  end
endmodule

// File: rtl/trig_timer_pair.sv
module trig_timer_pair
  import tmr_pkg::*;
#(
  parameter int W = TMR_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic         wrSel,
  input  logic [2:0]   wrAddr,
  input  logic [W-1:0] wrData,
  input  logic         extIn,
  output logic [W-1:0] cntA,
  output logic [W-1:0] cntB,
  output logic         trgoA,
  output logic         trgoB,
  output logic         flagA,
  output logic         flagB,
  output logic         runA,
  output logic         runB
);
  localparam int N = 2;

  dpCtl_t       ctlV  [N];
  logic [W-1:0] cntV  [N];
  logic [W-1:0] pscV  [N];
  logic [W-1:0] arrV  [N];
  logic [2:0]   mmSel [N];
  logic         trgoV [N];
  logic         uevV  [N];
  logic         flagV [N];
  logic         cenV  [N];

  for (genvar gi = 0; gi < N; gi++) begin : g_tmr
    tmr_ctrl #(.W(W)) u_ctrl (
      .clk       (clk),
      .rstN      (rstN),
      .wrEn      (wrEn && (wrSel == 1'(gi))),
      .wrAddr    (wrAddr),
      .wrData    (wrData),
      .peerTrig  (trgoV[N-1-gi]),
      .extIn     (extIn),
      .uev       (uevV[gi]),
      .ctl       (ctlV[gi]),
      .pscVal    (pscV[gi]),
      .arrVal    (arrV[gi]),
      .masterSel (mmSel[gi]),
      .trgo      (trgoV[gi]),
      .flag      (flagV[gi]),
      .cen       (cenV[gi])
    );
    tmr_datapath #(.W(W)) u_dp (
      .clk     (clk),
      .rstN    (rstN),
      .ctl     (ctlV[gi]),
      .pscVal  (pscV[gi]),
      .arrVal  (arrV[gi]),
      .loadVal (wrData),
      .cnt     (cntV[gi]),
      .uev     (uevV[gi])
    );
  end

  assign cntA  = cntV[0];
  assign cntB  = cntV[1];
  assign trgoA = trgoV[0];
  assign trgoB = trgoV[1];
  assign flagA = flagV[0];
  assign flagB = flagV[1];
  assign runA  = cenV[0];
  assign runB  = cenV[1];
endmodule

// File: rtl/tmr_pair_checker.sv
module tmr_pair_checker
  import tmr_pkg::*;
#(
  parameter int W = TMR_W
) (
  input logic         clk,
  input logic         rstN,
  input logic         wrEn,
  input logic         wrSel,
  input logic [2:0]   wrAddr,
  input logic [W-1:0] wrData,
  input logic [W-1:0] cntA,
  input logic         trgoA,
  input logic         flagA,
  input logic         flagB,
  input logic         runA,
  input logic [2:0]   mmsA,
  input logic [W-1:0] arrA
);
  assert_reset_state_R1: assert property (@(posedge clk)
    !rstN |=> (cntA == '0 && !flagA && !runA && !flagB));

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cntA) |-> (cntA == $past(cntA) + 1'b1) || (cntA == '0) || $past(wrEn));

  assert_update_at_limit_R3: assert property (@(posedge clk) disable iff (!rstN)
    (mmsA == MM_UPDATE && trgoA) |-> (cntA == arrA));

  assert_wrap_after_update_R3: assert property (@(posedge clk) disable iff (!rstN)
    (mmsA == MM_UPDATE && trgoA && !wrEn) |=> (cntA == '0));

  assert_enable_output_R4: assert property (@(posedge clk) disable iff (!rstN)
    (mmsA == MM_ENABLE) |-> (trgoA == runA));

  assert_flag_clear_only_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flagA) |-> $past(wrEn && !wrSel && wrAddr == ADR_STAT && !wrData[0]));

  assert_flagb_clear_only_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flagB) |-> $past(wrEn && wrSel && wrAddr == ADR_STAT && !wrData[0]));

  assert_run_clear_only_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(runA) |-> $past(wrEn && !wrSel && wrAddr == ADR_CTRL && !wrData[0]));
endmodule

bind trig_timer_pair tmr_pair_checker #(.W(W)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .wrEn   (wrEn),
  .wrSel  (wrSel),
  .wrAddr (wrAddr),
  .wrData (wrData),
  .cntA   (cntA),
  .trgoA  (trgoA),
  .flagA  (flagA),
  .flagB  (flagB),
  .runA   (runA),
  .mmsA   (mmSel[0]),
  .arrA   (arrV[0])
);

// File: tb/sim_trig_timer_pair.sv
`timescale 1ns/1ps
module sim_trig_timer_pair;
  import tmr_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        wrSel = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        extIn = 1'b0;
  logic [15:0] cntA, cntB;
  logic        trgoA, trgoB, flagA, flagB, runA, runB;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  trig_timer_pair u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrAddr(wrAddr),
    .wrData(wrData), .extIn(extIn), .cntA(cntA), .cntB(cntB),
    .trgoA(trgoA), .trgoB(trgoB), .flagA(flagA), .flagB(flagB),
    .runA(runA), .runB(runB)
  );

  // expected outputs after each clock of the update-trigger scenario
  typedef struct packed {
    logic [15:0] eCntA;
    logic        eTrgoA;
    logic        eRunB;
    logic        eFlagB;
    logic [15:0] eCntB;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{16'd0, 1'b0, 1'b0, 1'b0, 16'h0045},
    '{16'd1, 1'b0, 1'b0, 1'b0, 16'h0045},
    '{16'd1, 1'b0, 1'b0, 1'b0, 16'h0045},
    '{16'd2, 1'b0, 1'b0, 1'b0, 16'h0045},
    '{16'd2, 1'b1, 1'b0, 1'b0, 16'h0045},
    '{16'd0, 1'b0, 1'b1, 1'b1, 16'h0045},
    '{16'd0, 1'b0, 1'b1, 1'b1, 16'h0046},
    '{16'd1, 1'b0, 1'b1, 1'b1, 16'h0047}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [2:0] adr, input logic [15:0] dat);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrAddr = adr; wrData = dat;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; wrEn = 1'b0; extIn = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic extPulse();
    @(negedge clk); extIn = 1'b1;
    @(negedge clk); extIn = 1'b0;
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual running expected finished");
    finishRun();
  end

  initial begin
    logic [15:0] snap;
    // R1: reset state
    repeat (2) @(negedge clk);
    chk("R1 cntA in reset", cntA, 0);
    chk("R1 outputs in reset", {flagA, flagB, runA, runB, trgoA, trgoB}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 cntB after reset", cntB, 0);

    // Update-event output of A starts B (R2 R3 R5 R7)
    wr(1'b0, ADR_PSC, 16'd1);
    wr(1'b0, ADR_ARR, 16'd2);
    wr(1'b0, ADR_MODE, 16'h0002);
    wr(1'b1, ADR_MODE, 16'h0610);
    wr(1'b1, ADR_CNT, 16'h0045);
    wr(1'b0, ADR_CTRL, 16'h0001);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R2 R3 cntA per cycle", cntA, VEC[i].eCntA);
      chk("R3 trgoA update pulse", trgoA, VEC[i].eTrgoA);
      chk("R5 runB from update", runB, VEC[i].eRunB);
      chk("R7 flagB from update", flagB, VEC[i].eFlagB);
      chk("R5 cntB resumes", cntB, VEC[i].eCntB);
    end

    // Enable output of A starts B (R4 R5)
    doReset();
    wr(1'b0, ADR_MODE, 16'h0001);
    wr(1'b1, ADR_MODE, 16'h0610);
    wr(1'b1, ADR_CNT, 16'h00E7);
    wr(1'b0, ADR_CTRL, 16'h0001);
    chk("R4 trgoA follows run", trgoA, 1);
    chk("R5 runB one cycle later", runB, 0);
    @(negedge clk);
    chk("R5 runB set", runB, 1);
    chk("R7 flagB set", flagB, 1);
    chk("R5 cntB holds start value", cntB, 16'h00E7);
    @(negedge clk);
    chk("R5 cntB counts from E7", cntB, 16'h00E8);
    wr(1'b0, ADR_CTRL, 16'h0000);
    chk("R4 trgoA low after stop", trgoA, 0);

    // One external edge starts both (R9)
    doReset();
    wr(1'b0, ADR_MODE, 16'h0641);
    wr(1'b0, ADR_CTRL, 16'h0002);
    wr(1'b1, ADR_MODE, 16'h0610);
    wr(1'b0, ADR_PSC, 16'd1);
    wr(1'b1, ADR_PSC, 16'd1);
    wr(1'b0, ADR_EVT, 16'h0001);
    wr(1'b1, ADR_EVT, 16'h0001);
    @(negedge clk); extIn = 1'b1;
    @(negedge clk); extIn = 1'b0;
    chk("R9 runA set at once", runA, 1);
    chk("R9 flags held back", {flagA, flagB}, 0);
    @(negedge clk);
    chk("R9 flags set together", {flagA, flagB}, 2'b11);
    chk("R9 runB set", runB, 1);
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      chk("R9 cntA value", cntA, k / 2);
      chk("R9 counters aligned", cntB, cntA);
    end

    // R6: unselected source and non-trigger slave mode
    doReset();
    wr(1'b0, ADR_MODE, 16'h0600);
    extPulse();
    @(negedge clk);
    chk("R6 no source no run", {runA, flagA}, 0);
    wr(1'b0, ADR_MODE, 16'h0040);
    extPulse();
    @(negedge clk);
    chk("R6 slave mode off no run", {runA, flagA}, 0);

    // R7: trigger and flag clear in the same cycle
    wr(1'b0, ADR_MODE, 16'h0640);
    @(negedge clk);
    extIn = 1'b1; wrEn = 1'b1; wrSel = 1'b0; wrAddr = ADR_STAT; wrData = 16'h0000;
    @(negedge clk);
    extIn = 1'b0; wrEn = 1'b0;
    chk("R7 set wins over clear", flagA, 1);
    chk("R5 runA set by ext edge", runA, 1);
    wr(1'b0, ADR_STAT, 16'h0000);
    chk("R7 flag cleared by write", flagA, 0);

    // R10: stop freezes counter; trigger beats stop write
    wr(1'b0, ADR_CTRL, 16'h0000);
    chk("R10 run cleared", runA, 0);
    snap = cntA;
    repeat (3) @(negedge clk);
    chk("R10 counter frozen", cntA, snap);
    @(negedge clk);
    extIn = 1'b1; wrEn = 1'b1; wrSel = 1'b0; wrAddr = ADR_CTRL; wrData = 16'h0000;
    @(negedge clk);
    extIn = 1'b0; wrEn = 1'b0;
    chk("R10 trigger beats stop", runA, 1);
    wr(1'b0, ADR_CTRL, 16'h0000);

    // R8: load and counter reset
    wr(1'b0, ADR_CNT, 16'h1234);
    chk("R8 counter load", cntA, 16'h1234);
    wr(1'b0, ADR_EVT, 16'h0001);
    chk("R8 counter reset strobe", cntA, 0);

    // R2: first increment after divider period of 4
    doReset();
    wr(1'b0, ADR_PSC, 16'd3);
    wr(1'b0, ADR_CTRL, 16'h0001);
    repeat (3) @(negedge clk);
    chk("R2 no increment before period", cntA, 0);
    @(negedge clk);
    chk("R2 first increment at period", cntA, 1);
    repeat (4) @(negedge clk);
    chk("R2 second increment", cntA, 2);

    finishRun();
  end
endmodule